// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt Control Registers

This block keeps the machine-level trap state of a small 32-bit core that runs in only two privilege levels, machine and user. It holds the status word, interrupt enables, the pending view, the trap vector base, the saved exception PC, the cause and trap value registers and a scratch word. Software reaches these through a single-cycle CSR port that carries a 12-bit address, a two-bit operation, write data and combinational read data.

The pipeline pulses `trap_i` with a cause and a faulting PC to enter a trap. It pulses `mret_i` to return from one. Both update the status word and the privilege level together on one clock edge. The block also supplies the vectored handler address, the return address and the current privilege. It produces one interrupt-pending qualifier that already accounts for the global enable and the privilege level.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset the status word reads 0x0000_1800, the vector register reads 0x0000_0001, and the enable, exception PC, cause, trap value and scratch registers read zero. The privilege output is 2'b11 (machine).
- R2: A trap entry has the following effects on the next edge. The previous-enable bit (status bit 7) takes the old global enable (bit 3), and bit 3 clears. The previous-privilege field (bits 12:11) takes the current privilege, and the privilege becomes machine. The exception PC takes `trap_pc_i`. The cause register reads {`trap_irq_i`, 26 zeros, `trap_code_i`}.
- R3: An MRET has the following effects on the next edge. Bit 3 takes bit 7 and bit 7 sets. The privilege takes bits 12:11, and bits 12:11 become 2'b00 (user). `ret_pc_o` always shows the saved exception PC. When a trap entry arrives in the same cycle as an MRET, the trap entry wins.
- R4: Status writes store only bits 3, 7, 12:11, 17 and 21, and all other bits read zero. A written previous-privilege value of 2'b01 or 2'b10 is stored as 2'b11.
- R5: The vector register (address 0x305) always reads 2'b01 in bits 1:0 and zero in bits 7:2. Only bits 31:8 are writable.
- R6: `trap_pc_o` is the vector base plus 4 times `trap_code_i` when `trap_irq_i` is high, and the vector base alone when it is low.
- R7: The enable register (0x304) stores bits 3 (software), 7 (timer), 11 (external) and 16+x (fast input x). The pending register (0x344) reads each of those bits as the matching input ANDed with its enable.
- R8: The trap value register keeps `trap_val_i` only for exception codes 2, 4, 5, 6 and 7 with `trap_irq_i` low. For all other traps it is zeroed.
- R9: `csr_op_i` selects among four operations: 0 read, 1 write, 2 set bits, 3 clear bits. `csr_rdata_o` shows the addressed register's current value in the same cycle.
- R10: `csr_illegal_o` rises in the same cycle as a request in any of three cases: an unknown address, a non-read operation on the pending register (0x344), or any access while the privilege is user. Such a request changes no state.
- R11: A CSR write, set or clear that coincides with a trap entry or an MRET is dropped.
- R12: `irq_pending_o` is high when any pending bit is set and either the privilege is user or status bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_req_i | input | 1 | CSR access request |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | 32 | Write/set/clear operand |
| csr_rdata_o | output | 32 | Read data of addressed CSR |
| csr_illegal_o | output | 1 | Access refused |
| trap_i | input | 1 | Trap entry strobe |
| trap_irq_i | input | 1 | Trap caused by an interrupt |
| trap_code_i | input | 5 | Exception or interrupt code |
| trap_pc_i | input | 32 | PC of the trapping instruction |
| trap_val_i | input | 32 | Candidate trap value |
| mret_i | input | 1 | Return-from-trap strobe |
| irq_sw_i | input | 1 | Software interrupt line |
| irq_timer_i | input | 1 | Timer interrupt line |
| irq_ext_i | input | 1 | External interrupt line |
| irq_fast_i | input | NUM_FAST (15) | Fast interrupt lines |
| trap_pc_o | output | 32 | Handler address for the current trap inputs |
| ret_pc_o | output | 32 | Return address (saved exception PC) |
| priv_o | output | 2 | Current privilege, 2'b11 machine, 2'b00 user |
| irq_pending_o | output | 1 | Qualified interrupt pending |

## Verification
Trap entry can arrive in the same cycle as a CSR write, and in the same cycle as an MRET. The bench drives both strobes on one negative edge. One case pairs a trap with a write to the exception PC. Another pairs a trap with an MRET that would otherwise drop to user mode. A third pairs an MRET with a scratch write. After the next rising edge the bench reads back the exception PC, the status word, the scratch word and the privilege output. These show that the trap result stands and the competing update left no trace.

// File: rtl/mtrap_csr_pkg.sv
package mtrap_csr_pkg;

   localparam int unsigned XLEN = 32;

   localparam logic [1:0] OP_READ  = 2'd0;
   localparam logic [1:0] OP_WRITE = 2'd1;
   localparam logic [1:0] OP_SET   = 2'd2;
   localparam logic [1:0] OP_CLEAR = 2'd3;

   localparam logic [1:0] PRV_USER    = 2'b00;
   localparam logic [1:0] PRV_MACHINE = 2'b11;

   localparam logic [11:0] A_STATUS  = 12'h300;
   localparam logic [11:0] A_IRQEN   = 12'h304;
   localparam logic [11:0] A_VECTOR  = 12'h305;
   localparam logic [11:0] A_SCRATCH = 12'h340;
   localparam logic [11:0] A_EPC     = 12'h341;
   localparam logic [11:0] A_CAUSE   = 12'h342;
   localparam logic [11:0] A_TVAL    = 12'h343;
   localparam logic [11:0] A_IRQPEND = 12'h344;

   localparam int unsigned B_GIE   = 3;
   localparam int unsigned B_PGIE  = 7;
   localparam int unsigned B_PPRV  = 11;
   localparam int unsigned B_MPRV  = 17;
   localparam int unsigned B_TW    = 21;
   localparam int unsigned FAST_LO = 16;
   localparam int unsigned FAST_MAX = 15;

   function automatic logic [1:0] coerce_prv(input logic [1:0] v);
      return (v == PRV_USER) ? PRV_USER : PRV_MACHINE;
   endfunction

   function automatic logic [XLEN-1:0] apply_op(input logic [1:0] op,
                                                input logic [XLEN-1:0] cur,
                                                input logic [XLEN-1:0] arg);
      case (op)
         OP_SET:   return cur | arg;
         OP_CLEAR: return cur & ~arg;
         default:  return arg;
      endcase
   endfunction

   function automatic logic keeps_tval(input logic irq, input logic [4:0] code);
      if (irq) return 1'b0;
      return (code == 5'd2) || (code == 5'd4) || (code == 5'd5) ||
             (code == 5'd6) || (code == 5'd7);
   endfunction

endpackage

// File: rtl/mtrap_csr_status.sv
module mtrap_csr_status
   import mtrap_csr_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_en_i,
   input  logic [XLEN-1:0] wr_val_i,
   input  logic            trap_i,
   input  logic            mret_i,
   output logic [XLEN-1:0] status_o,
   output logic [1:0]      priv_o
);
   logic       gie_q, pgie_q, mprv_q, tw_q;
   logic [1:0] pprv_q, priv_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gie_q  <= 1'b0;
         pgie_q <= 1'b0;
         pprv_q <= PRV_MACHINE;
         mprv_q <= 1'b0;
         tw_q   <= 1'b0;
         priv_q <= PRV_MACHINE;
      end else if (trap_i) begin
         pgie_q <= gie_q;
         gie_q  <= 1'b0;
         pprv_q <= priv_q;
         priv_q <= PRV_MACHINE;
      end else if (mret_i) begin
         gie_q  <= pgie_q;
         pgie_q <= 1'b1;
         priv_q <= pprv_q;
         pprv_q <= PRV_USER;
      end else if (wr_en_i) begin
         gie_q  <= wr_val_i[B_GIE];
         pgie_q <= wr_val_i[B_PGIE];
         pprv_q <= coerce_prv(wr_val_i[B_PPRV +: 2]);
         mprv_q <= wr_val_i[B_MPRV];
         tw_q   <= wr_val_i[B_TW];
      end
   end

   always_comb begin
      status_o              = '0;
      status_o[B_GIE]       = gie_q;
      status_o[B_PGIE]      = pgie_q;
      status_o[B_PPRV +: 2] = pprv_q;
      status_o[B_MPRV]      = mprv_q;
      status_o[B_TW]        = tw_q;
   end

   assign priv_o = priv_q;

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_val_i[31:22], wr_val_i[20:18], wr_val_i[16:13],
                             wr_val_i[10:8], wr_val_i[6:4], wr_val_i[2:0]};
endmodule

// File: rtl/mtrap_csr_irq.sv
module mtrap_csr_irq
   import mtrap_csr_pkg::*;
#(
   parameter int unsigned NUM_FAST = 15
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic [XLEN-1:0]     wr_val_i,
   input  logic                irq_sw_i,
   input  logic                irq_timer_i,
   input  logic                irq_ext_i,
   input  logic [NUM_FAST-1:0] irq_fast_i,
   output logic [XLEN-1:0]     irqen_o,
   output logic [XLEN-1:0]     irqpend_o
);
   if (NUM_FAST < 1 || NUM_FAST > FAST_MAX) begin : g_bad_fast
      $error("NUM_FAST must lie between 1 and 15");
   end

   logic                sw_en_q, tm_en_q, ex_en_q;
   logic [NUM_FAST-1:0] fast_en_q;
   logic [FAST_MAX-1:0] fast_en_w, fast_pend_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sw_en_q   <= 1'b0;
         tm_en_q   <= 1'b0;
         ex_en_q   <= 1'b0;
         fast_en_q <= '0;
      end else if (wr_en_i) begin
         sw_en_q   <= wr_val_i[3];
         tm_en_q   <= wr_val_i[7];
         ex_en_q   <= wr_val_i[11];
         fast_en_q <= wr_val_i[FAST_LO +: NUM_FAST];
      end
   end

   for (genvar i = 0; i < FAST_MAX; i++) begin : g_fast
      if (i < NUM_FAST) begin : g_used
         assign fast_en_w[i]   = fast_en_q[i];
         assign fast_pend_w[i] = fast_en_q[i] & irq_fast_i[i];
      end else begin : g_tied
         assign fast_en_w[i]   = 1'b0;
         assign fast_pend_w[i] = 1'b0;
      end
   end

   assign irqen_o   = {1'b0, fast_en_w, 4'b0, ex_en_q, 3'b0, tm_en_q, 3'b0, sw_en_q, 3'b0};
   assign irqpend_o = {1'b0, fast_pend_w, 4'b0, ex_en_q & irq_ext_i, 3'b0,
                       tm_en_q & irq_timer_i, 3'b0, sw_en_q & irq_sw_i, 3'b0};

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_val_i[31:FAST_LO+NUM_FAST], wr_val_i[15:12],
                             wr_val_i[10:8], wr_val_i[6:4], wr_val_i[2:0]};
endmodule

// File: rtl/mtrap_csr_vector.sv
module mtrap_csr_vector
   import mtrap_csr_pkg::*;
#(
   parameter int unsigned     ALIGN_BITS = 8,
   parameter logic [XLEN-1:0] RESET_BASE = '0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_en_i,
   input  logic [XLEN-1:0] wr_val_i,
   input  logic            irq_i,
   input  logic [4:0]      code_i,
   output logic [XLEN-1:0] vector_o,
   output logic [XLEN-1:0] target_o
);
   if (ALIGN_BITS < 7 || ALIGN_BITS > 30) begin : g_bad_align
      $error("ALIGN_BITS must leave room for 32 vector slots");
   end

   logic [XLEN-1:ALIGN_BITS] base_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      base_q <= RESET_BASE[XLEN-1:ALIGN_BITS];
      else if (wr_en_i) base_q <= wr_val_i[XLEN-1:ALIGN_BITS];
   end

   logic [XLEN-1:0] base_w;
   assign base_w   = {base_q, {ALIGN_BITS{1'b0}}};
   assign vector_o = {base_q, {(ALIGN_BITS-2){1'b0}}, 2'b01};
   assign target_o = irq_i ? (base_w | XLEN'({code_i, 2'b00})) : base_w;

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_val_i[ALIGN_BITS-1:0];
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
   import mtrap_csr_pkg::*;
#(
   parameter int unsigned     NUM_FAST   = 15,
   parameter int unsigned     ALIGN_BITS = 8,
   parameter logic [XLEN-1:0] VEC_RESET  = '0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                csr_req_i,
   input  logic [11:0]         csr_addr_i,
   input  logic [1:0]          csr_op_i,
   input  logic [XLEN-1:0]     csr_wdata_i,
   output logic [XLEN-1:0]     csr_rdata_o,
   output logic                csr_illegal_o,
   input  logic                trap_i,
   input  logic                trap_irq_i,
   input  logic [4:0]          trap_code_i,
   input  logic [XLEN-1:0]     trap_pc_i,
   input  logic [XLEN-1:0]     trap_val_i,
   input  logic                mret_i,
   input  logic                irq_sw_i,
   input  logic                irq_timer_i,
   input  logic                irq_ext_i,
   input  logic [NUM_FAST-1:0] irq_fast_i,
   output logic [XLEN-1:0]     trap_pc_o,
   output logic [XLEN-1:0]     ret_pc_o,
   output logic [1:0]          priv_o,
   output logic                irq_pending_o
);
   logic [XLEN-1:0] status_w, irqen_w, irqpend_w, vector_w, wr_val_w;
   logic [XLEN-1:0] epc_q, tval_q, scratch_q;
   logic            cause_irq_q;
   logic [4:0]      cause_code_q;
   logic            known_w, wr_ok_w;

   always_comb begin
      known_w     = 1'b1;
      csr_rdata_o = '0;
      case (csr_addr_i)
         A_STATUS:  csr_rdata_o = status_w;
         A_IRQEN:   csr_rdata_o = irqen_w;
         A_VECTOR:  csr_rdata_o = vector_w;
         A_SCRATCH: csr_rdata_o = scratch_q;
         A_EPC:     csr_rdata_o = epc_q;
         A_CAUSE:   csr_rdata_o = {cause_irq_q, 26'b0, cause_code_q};
         A_TVAL:    csr_rdata_o = tval_q;
         A_IRQPEND: csr_rdata_o = irqpend_w;
         default:   known_w     = 1'b0;
      endcase
   end

   assign csr_illegal_o = csr_req_i &&
                          (!known_w || (priv_o == PRV_USER) ||
                           ((csr_addr_i == A_IRQPEND) && (csr_op_i != OP_READ)));
   assign wr_ok_w  = csr_req_i && (csr_op_i != OP_READ) && !csr_illegal_o &&
                     !trap_i && !mret_i;
   assign wr_val_w = apply_op(csr_op_i, csr_rdata_o, csr_wdata_i);

   mtrap_csr_status u_status (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_ok_w && (csr_addr_i == A_STATUS)),
      .wr_val_i (wr_val_w),
      .trap_i   (trap_i),
      .mret_i   (mret_i),
      .status_o (status_w),
      .priv_o   (priv_o)
   );

   mtrap_csr_irq #(.NUM_FAST(NUM_FAST)) u_irq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_ok_w && (csr_addr_i == A_IRQEN)),
      .wr_val_i    (wr_val_w),
      .irq_sw_i    (irq_sw_i),
      .irq_timer_i (irq_timer_i),
      .irq_ext_i   (irq_ext_i),
      .irq_fast_i  (irq_fast_i),
      .irqen_o     (irqen_w),
      .irqpend_o   (irqpend_w)
   );

   mtrap_csr_vector #(.ALIGN_BITS(ALIGN_BITS), .RESET_BASE(VEC_RESET)) u_vector (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_ok_w && (csr_addr_i == A_VECTOR)),
      .wr_val_i (wr_val_w),
      .irq_i    (trap_irq_i),
      .code_i   (trap_code_i),
      .vector_o (vector_w),
      .target_o (trap_pc_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         epc_q        <= '0;
         tval_q       <= '0;
         scratch_q    <= '0;
         cause_irq_q  <= 1'b0;
         cause_code_q <= '0;
      end else if (trap_i) begin
         epc_q        <= trap_pc_i;
         tval_q       <= keeps_tval(trap_irq_i, trap_code_i) ? trap_val_i : '0;
         cause_irq_q  <= trap_irq_i;
         cause_code_q <= trap_code_i;
      end else if (wr_ok_w) begin
         if (csr_addr_i == A_EPC)     epc_q     <= wr_val_w;
         if (csr_addr_i == A_TVAL)    tval_q    <= wr_val_w;
         if (csr_addr_i == A_SCRATCH) scratch_q <= wr_val_w;
         if (csr_addr_i == A_CAUSE) begin
            cause_irq_q  <= wr_val_w[XLEN-1];
            cause_code_q <= wr_val_w[4:0];
         end
      end
   end

   assign ret_pc_o      = epc_q;
   assign irq_pending_o = (|irqpend_w) && ((priv_o == PRV_USER) || status_w[B_GIE]);
endmodule

// File: rtl/mtrap_csr_unit_chk.sv
module mtrap_csr_unit_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        csr_req_i,
   input logic        csr_illegal_o,
   input logic        trap_i,
   input logic [31:0] trap_pc_i,
   input logic        mret_i,
   input logic [1:0]  priv_o,
   input logic        irq_pending_o,
   input logic [31:0] status_w,
   input logic [31:0] vector_w,
   input logic [31:0] irqpend_w,
   input logic [31:0] epc_q,
   input logic [31:0] scratch_q
);
   p_trap_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_i |=> (priv_o == 2'b11) && !status_w[3] &&
                 (status_w[7] == $past(status_w[3])) &&
                 (status_w[12:11] == $past(priv_o)) && (epc_q == $past(trap_pc_i)));

   p_mret_restore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mret_i && !trap_i) |=> (priv_o == $past(status_w[12:11])) &&
                              (status_w[3] == $past(status_w[7])) && status_w[7]);

   p_pprv_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_w[12:11] == 2'b00) || (status_w[12:11] == 2'b11));

   p_vector_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vector_w[7:0] == 8'h01);

   p_illegal_inert_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_req_i && csr_illegal_o && !trap_i && !mret_i) |=>
         $stable(status_w) && $stable(epc_q) && $stable(scratch_q));

   p_pending_source_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_pending_o |-> (irqpend_w != 32'h0));
endmodule

bind mtrap_csr_unit mtrap_csr_unit_chk u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .csr_req_i     (csr_req_i),
   .csr_illegal_o (csr_illegal_o),
   .trap_i        (trap_i),
   .trap_pc_i     (trap_pc_i),
   .mret_i        (mret_i),
   .priv_o        (priv_o),
   .irq_pending_o (irq_pending_o),
   .status_w      (status_w),
   .vector_w      (vector_w),
   .irqpend_w     (irqpend_w),
   .epc_q         (epc_q),
   .scratch_q     (scratch_q)
);

// File: tb/mtrap_csr_unit_tb.sv
module mtrap_csr_unit_tb_top;
   localparam logic [1:0] RD = 2'd0, WR = 2'd1, ST = 2'd2, CL = 2'd3;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        csr_req = 0, csr_illegal;
   logic [11:0] csr_addr = '0;
   logic [1:0]  csr_op = '0;
   logic [31:0] csr_wdata = '0, csr_rdata;
   logic        trap = 0, trap_irq = 0, mret = 0;
   logic [4:0]  trap_code = '0;
   logic [31:0] trap_pc = '0, trap_val = '0, trap_pc_out, ret_pc;
   logic        irq_sw = 0, irq_timer = 0, irq_ext = 0, irq_pending;
   logic [14:0] irq_fast = '0;
   logic [1:0]  priv;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   mtrap_csr_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .csr_req_i(csr_req), .csr_addr_i(csr_addr),
      .csr_op_i(csr_op), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
      .csr_illegal_o(csr_illegal), .trap_i(trap), .trap_irq_i(trap_irq),
      .trap_code_i(trap_code), .trap_pc_i(trap_pc), .trap_val_i(trap_val),
      .mret_i(mret), .irq_sw_i(irq_sw), .irq_timer_i(irq_timer), .irq_ext_i(irq_ext),
      .irq_fast_i(irq_fast), .trap_pc_o(trap_pc_out), .ret_pc_o(ret_pc),
      .priv_o(priv), .irq_pending_o(irq_pending)
   );

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual 0x%08h expected 0x%08h", r, act, exp);
      end
   endtask

   task automatic acc(input logic [1:0] op, input logic [11:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic ill);
      @(negedge clk);
      csr_req = 1; csr_op = op; csr_addr = a; csr_wdata = wd;
      #1 rd = csr_rdata; ill = csr_illegal;
      @(posedge clk); #1 csr_req = 0; csr_op = RD;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] wd);
      logic [31:0] rd; logic ill;
      acc(WR, a, wd, rd, ill);
   endtask

   task automatic rd_chk(input string r, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] rd; logic ill;
      acc(RD, a, '0, rd, ill);
      chk(r, rd, exp);
   endtask

   task automatic do_trap(input logic irq, input logic [4:0] code, input logic [31:0] pc,
                          input logic [31:0] val, output logic [31:0] tgt);
      @(negedge clk);
      trap = 1; trap_irq = irq; trap_code = code; trap_pc = pc; trap_val = val;
      #1 tgt = trap_pc_out;
      @(posedge clk); #1 trap = 0;
   endtask

   task automatic do_mret();
      @(negedge clk); mret = 1;
      @(posedge clk); #1 mret = 0;
   endtask

   task automatic t_reset();
      chk("R1 priv", 32'(priv), 32'h3);
      rd_chk("R1 status", 12'h300, 32'h0000_1800);
      rd_chk("R1 vector", 12'h305, 32'h0000_0001);
      rd_chk("R1 irqen", 12'h304, 32'h0);
      rd_chk("R1 epc", 12'h341, 32'h0);
      rd_chk("R1 cause", 12'h342, 32'h0);
      rd_chk("R1 tval", 12'h343, 32'h0);
      rd_chk("R1 scratch", 12'h340, 32'h0);
   endtask

   task automatic t_ops();
      logic [31:0] rd; logic ill;
      wr(12'h340, 32'hA5A5_0F0F);
      rd_chk("R9 write", 12'h340, 32'hA5A5_0F0F);
      acc(ST, 12'h340, 32'h0000_F000, rd, ill);
      chk("R9 old value on set", rd, 32'hA5A5_0F0F);
      rd_chk("R9 set", 12'h340, 32'hA5A5_FF0F);
      acc(CL, 12'h340, 32'hA500_0000, rd, ill);
      rd_chk("R9 clear", 12'h340, 32'h00A5_FF0F);
   endtask

   task automatic t_status();
      wr(12'h300, 32'hFFFF_FFFF);
      rd_chk("R4 field mask", 12'h300, 32'h0022_1888);
      wr(12'h300, 32'h0000_0800);
      rd_chk("R4 pprv 01 coerced", 12'h300, 32'h0000_1800);
      wr(12'h300, 32'h0000_1000);
      rd_chk("R4 pprv 10 coerced", 12'h300, 32'h0000_1800);
      wr(12'h300, 32'h0);
      rd_chk("R4 pprv 00 kept", 12'h300, 32'h0);
   endtask

   task automatic t_vector();
      wr(12'h305, 32'hFFFF_FFFF);
      rd_chk("R5 all ones", 12'h305, 32'hFFFF_FF01);
      wr(12'h305, 32'h1234_5678);
      rd_chk("R5 pattern", 12'h305, 32'h1234_5601);
   endtask

   task automatic t_irq();
      logic [31:0] rd; logic ill;
      wr(12'h304, 32'hFFFF_FFFF);
      rd_chk("R7 enable mask", 12'h304, 32'h7FFF_0888);
      @(negedge clk); irq_sw = 1; irq_fast = 15'b100;
      rd_chk("R7 pending gated", 12'h344, 32'h0004_0008);
      chk("R12 masked by global enable", 32'(irq_pending), 32'h0);
      wr(12'h300, 32'h8);
      #1 chk("R12 pending with enable", 32'(irq_pending), 32'h1);
      acc(CL, 12'h304, 32'h8, rd, ill);
      rd_chk("R7 pending after disable", 12'h344, 32'h0004_0000);
      acc(WR, 12'h344, 32'hFFFF_FFFF, rd, ill);
      chk("R10 write to pending", 32'(ill), 32'h1);
      acc(RD, 12'h344, 32'h0, rd, ill);
      chk("R10 read of pending legal", 32'(ill), 32'h0);
      acc(RD, 12'h345, 32'h0, rd, ill);
      chk("R10 unknown address", 32'(ill), 32'h1);
      @(negedge clk); irq_sw = 0; irq_fast = '0;
      wr(12'h304, 32'h0);
      wr(12'h300, 32'h0);
   endtask

   task automatic t_trap();
      logic [31:0] tgt;
      wr(12'h305, 32'h0000_4000);
      wr(12'h300, 32'h8);
      do_trap(1'b1, 5'd7, 32'h80, 32'hDEAD, tgt);
      chk("R6 interrupt target", tgt, 32'h0000_401C);
      rd_chk("R2 status stacked", 12'h300, 32'h0000_1880);
      rd_chk("R2 epc", 12'h341, 32'h80);
      rd_chk("R2 cause irq", 12'h342, 32'h8000_0007);
      rd_chk("R8 tval zero for interrupt", 12'h343, 32'h0);
      do_trap(1'b0, 5'd2, 32'h84, 32'h0BAD, tgt);
      chk("R6 exception target", tgt, 32'h0000_4000);
      rd_chk("R2 cause exception", 12'h342, 32'h2);
      rd_chk("R8 tval illegal instr", 12'h343, 32'h0BAD);
      rd_chk("R2 status second", 12'h300, 32'h0000_1800);
      do_trap(1'b0, 5'd3, 32'h88, 32'h55, tgt);
      rd_chk("R8 tval other code", 12'h343, 32'h0);
   endtask

   task automatic t_mret();
      logic [31:0] rd, tgt; logic ill;
      wr(12'h300, 32'h1880);
      wr(12'h341, 32'h100);
      do_mret();
      chk("R3 stay machine", 32'(priv), 32'h3);
      rd_chk("R3 status after return", 12'h300, 32'h0000_0088);
      wr(12'h300, 32'h0);
      wr(12'h341, 32'h200);
      #1 chk("R3 ret pc", ret_pc, 32'h200);
      wr(12'h304, 32'h80);
      @(negedge clk); irq_timer = 1;
      do_mret();
      chk("R3 priv user", 32'(priv), 32'h0);
      chk("R12 pending in user", 32'(irq_pending), 32'h1);
      acc(RD, 12'h340, 32'h0, rd, ill);
      chk("R10 user access", 32'(ill), 32'h1);
      acc(WR, 12'h340, 32'hFFFF, rd, ill);
      @(negedge clk); irq_timer = 0;
      do_trap(1'b0, 5'd8, 32'h204, 32'h77, tgt);
      chk("R2 priv back to machine", 32'(priv), 32'h3);
      rd_chk("R2 pprv user saved", 12'h300, 32'h0);
      rd_chk("R10 scratch untouched", 12'h340, 32'h00A5_FF0F);
      rd_chk("R8 tval ecall", 12'h343, 32'h0);
      wr(12'h304, 32'h0);
   endtask

   task automatic t_collide();
      @(negedge clk);
      csr_req = 1; csr_op = WR; csr_addr = 12'h341; csr_wdata = 32'h1234;
      trap = 1; trap_irq = 0; trap_code = 5'd3; trap_pc = 32'h300;
      @(posedge clk); #1 csr_req = 0; trap = 0;
      rd_chk("R11 trap beats epc write", 12'h341, 32'h300);
      wr(12'h300, 32'h1800);
      @(negedge clk);
      csr_req = 1; csr_op = WR; csr_addr = 12'h340; csr_wdata = 32'h77;
      mret = 1;
      @(posedge clk); #1 csr_req = 0; mret = 0;
      rd_chk("R11 mret drops scratch write", 12'h340, 32'h00A5_FF0F);
      wr(12'h300, 32'h80);
      @(negedge clk);
      trap = 1; trap_code = 5'd1; trap_pc = 32'h400; mret = 1;
      @(posedge clk); #1 trap = 0; mret = 0;
      chk("R3 trap beats mret priv", 32'(priv), 32'h3);
      rd_chk("R3 trap beats mret status", 12'h300, 32'h0000_1800);
      rd_chk("R3 trap beats mret epc", 12'h341, 32'h400);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_ops();
      t_status();
      t_vector();
      t_irq();
      t_trap();
      t_mret();
      t_collide();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule